// File: doc/BRIEF.md
# Shadowed Single-Channel PWM Generator

This block produces one pulse-width-modulated output from a free-running up-counter and a small register file reached over a simple synchronous bus. Two active registers shape the waveform. The period register sets where the counter wraps. The compare register sets where the output changes level. A second pair of shadow registers lets software queue the next period and compare values while the waveform is running. The queued pair is copied into the active pair only when the counter wraps, so the cycle in progress always completes unchanged.

A control register has four fields. The first starts and stops the counter. The second enables the waveform; while it is off, the output is held low. The third inverts the output, so the compare value then sets the low time instead of the high time. The fourth decides whether an external sync pulse may restart the counter. The intended flow has two cases. While the generator is stopped, software programs the active pair directly and then starts it. While the generator is running, software writes the shadow pair.

The bus addresses halfwords. A word access moves 32 bits. A halfword access moves 16 bits, in the lower or upper half as the lowest address bit selects. Read data appears one clock after the request.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After reset, all registers read 0, the counter is stopped at 0 and `pwm_out` is low.
- R2: Halfword addresses are: active period 0, active compare 2, shadow period 4, shadow compare 6, control 8. A word access (`bus_half`=0) ignores `bus_addr[0]`. A halfword access uses `bus_wdata[15:0]` and returns its data in `bus_rdata[15:0]` with the upper bits zero; `bus_addr[0]`=1 selects the upper 16 bits of the word. The control word holds 5 bits (bit 0 run, bit 1 wave enable, bit 2 invert, bits 4:3 sync select), and its other bits read 0. Unmapped addresses read 0 and ignore writes. `bus_rdata` is updated on the clock edge that samples the read.
- R3: A write to an active register also writes the same full 32-bit value into its shadow register.
- R4: While run is 1, the counter increments by one each clock. In the clock after it equals the active period P, it becomes 0, so one cycle lasts P+1 clocks. P=1 gives an output that toggles every clock.
- R5: On the wrap clock, the shadow period and shadow compare values are copied into the active pair. Shadow writes never change the cycle in progress.
- R6: With wave enable 1 and invert 0, `pwm_out` is high exactly while counter < active compare. A compare of 0 gives a constant low output. A compare above the period gives a constant high output.
- R7: With invert 1, `pwm_out` is the complement of the R6 level.
- R8: With wave enable 0, `pwm_out` is low whatever the counter and run bit hold.
- R9: With run 0, the counter holds its value while wave enable is 1, and is cleared to 0 while wave enable is 0.
- R10: While running, a high `sync_in` clears the counter to 0 on the next clock without loading the shadow pair, unless sync select is 2'b11, in which case `sync_in` has no effect.
- R11: A bus write to an active register in the same clock as a wrap takes precedence over the shadow copy for that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = halfword access, 0 = word access |
| bus_addr | input | ADDR_W | Halfword address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after a read |
| sync_in | input | 1 | External counter restart pulse |
| pwm_out | output | 1 | Waveform output |

## Verification
Nearly every internal fault reaches `pwm_out` within one waveform cycle. A counter that is off by one, or that wraps one clock late, moves the next output edge. A shadow copy made at the wrong moment changes the high time of the very next cycle. A wrong polarity or enable state shows at once. The bench runs a behavioural model next to the design and compares the output on every clock. It also compares read data whenever a read is due. A wrong internal state is therefore reported within a few clocks of the moment it first becomes visible.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

    localparam int BUS_W = 32;

    // control word layout: bit0 run, bit1 wave enable, bit2 invert, bits4:3 sync select
    typedef struct packed {
        logic [1:0] sync_sel;
        logic       invert;
        logic       wave_en;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] SYNC_OFF = 2'b11;

endpackage

// File: rtl/apwm_regfile.sv
module apwm_regfile
    import apwm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel,
    input  logic                   we,
    input  logic                   half,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [BUS_W-1:0]       wdata,
    input  logic                   reload,
    output ctrl_t                  ctrl,
    output logic [CNT_W-1:0]       per_act,
    output logic [CNT_W-1:0]       cmp_act,
    output logic [BUS_W-1:0]       rdata
);

    localparam int IDX_W = ADDR_W - 1;
    localparam logic [IDX_W-1:0] I_PER_ACT = IDX_W'(0);
    localparam logic [IDX_W-1:0] I_CMP_ACT = IDX_W'(1);
    localparam logic [IDX_W-1:0] I_PER_SH  = IDX_W'(2);
    localparam logic [IDX_W-1:0] I_CMP_SH  = IDX_W'(3);
    localparam logic [IDX_W-1:0] I_CTRL    = IDX_W'(4);

    typedef struct packed {
        logic [CNT_W-1:0] per_act;
        logic [CNT_W-1:0] cmp_act;
        logic [CNT_W-1:0] per_sh;
        logic [CNT_W-1:0] cmp_sh;
        ctrl_t            ctrl;
        logic [BUS_W-1:0] rdata;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [IDX_W-1:0] idx;
    logic             upper;
    logic [BUS_W-1:0] cur_word;
    logic [BUS_W-1:0] wr_word;
    logic [BUS_W-1:0] rd_pick;
    logic             wr_en;

    assign idx   = addr[ADDR_W-1:1];
    assign upper = addr[0];
    assign wr_en = sel && we;

    always_comb begin
        case (idx)
            I_PER_ACT: cur_word = BUS_W'(st_q.per_act);
            I_CMP_ACT: cur_word = BUS_W'(st_q.cmp_act);
            I_PER_SH:  cur_word = BUS_W'(st_q.per_sh);
            I_CMP_SH:  cur_word = BUS_W'(st_q.cmp_sh);
            I_CTRL:    cur_word = BUS_W'(st_q.ctrl);
            default:   cur_word = '0;
        endcase

        if (!half) begin
            wr_word = wdata;
            rd_pick = cur_word;
        end else if (upper) begin
            wr_word = {wdata[15:0], cur_word[15:0]};
            rd_pick = {16'h0000, cur_word[31:16]};
        end else begin
            wr_word = {cur_word[31:16], wdata[15:0]};
            rd_pick = {16'h0000, cur_word[15:0]};
        end
    end

    always_comb begin
        st_d = st_q;

        // R5: shadow pair becomes active on the wrap clock
        if (reload) begin
            st_d.per_act = st_q.per_sh;
            st_d.cmp_act = st_q.cmp_sh;
        end

        // R3, R11: bus writes come after the reload, so they win
        if (wr_en) begin
            case (idx)
                I_PER_ACT: begin
                    st_d.per_act = CNT_W'(wr_word);
                    st_d.per_sh  = CNT_W'(wr_word);
                end
                I_CMP_ACT: begin
                    st_d.cmp_act = CNT_W'(wr_word);
                    st_d.cmp_sh  = CNT_W'(wr_word);
                end
                I_PER_SH:  st_d.per_sh = CNT_W'(wr_word);
                I_CMP_SH:  st_d.cmp_sh = CNT_W'(wr_word);
                I_CTRL:    st_d.ctrl   = ctrl_t'(wr_word[CTRL_W-1:0]);
                default:   ;
            endcase
        end

        if (sel && !we) begin
            st_d.rdata = rd_pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl    = st_q.ctrl;
    assign per_act = st_q.per_act;
    assign cmp_act = st_q.cmp_act;
    assign rdata   = st_q.rdata;

    // R5
    shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !(wr_en && idx == I_PER_ACT)) |=> (st_q.per_act == $past(st_q.per_sh)));

    // R3
    mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == I_PER_ACT) |=> (st_q.per_sh == st_q.per_act));

endmodule

// File: rtl/apwm_timebase.sv
module apwm_timebase #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wave_en,
    input  logic             sync_en,
    input  logic             sync_in,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             reload
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      sync_hit;

    assign sync_hit = run && sync_en && sync_in;
    assign reload   = run && !sync_hit && (st_q.cnt == period);

    always_comb begin
        st_d = st_q;
        if (run) begin
            if (sync_hit || reload) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else if (!wave_en) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sync_hit && count == period) |=> (count == '0));

    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sync_hit && count != period) |=> (count == $past(count) + CNT_W'(1)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && wave_en) |=> $stable(count));

    // R9
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wave_en) |=> (count == '0));

    // R10
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sync_en && sync_in) |=> (count == '0));

endmodule

// File: rtl/apwm_shaper.sv
module apwm_shaper #(
    parameter int CNT_W = 32
) (
    input  logic             wave_en,
    input  logic             invert,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] compare,
    output logic             wave
);

    logic below;

    always_comb begin
        below = (count < compare);
        wave  = wave_en & (below ^ invert);
    end

endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
    import apwm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_half,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              sync_in,
    output logic              pwm_out
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] per_act;
    logic [CNT_W-1:0] cmp_act;
    logic [CNT_W-1:0] count;
    logic             reload;
    logic             sync_en;

    assign sync_en = (ctrl.sync_sel != SYNC_OFF);

    apwm_regfile #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (bus_sel),
        .we      (bus_we),
        .half    (bus_half),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .reload  (reload),
        .ctrl    (ctrl),
        .per_act (per_act),
        .cmp_act (cmp_act),
        .rdata   (bus_rdata)
    );

    apwm_timebase #(.CNT_W(CNT_W)) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run),
        .wave_en (ctrl.wave_en),
        .sync_en (sync_en),
        .sync_in (sync_in),
        .period  (per_act),
        .count   (count),
        .reload  (reload)
    );

    apwm_shaper #(.CNT_W(CNT_W)) u_shape (
        .wave_en (ctrl.wave_en),
        .invert  (ctrl.invert),
        .count   (count),
        .compare (cmp_act),
        .wave    (pwm_out)
    );

    // R8
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.wave_en |-> !pwm_out);

    // R5
    no_reload_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |-> !reload);

endmodule

// File: tb/sim_pwm_shadow_gen.sv
module sim_pwm_shadow_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_half = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sync_in = 1'b0;
    logic        pwm_out;

    always #5 clk = ~clk;

    pwm_shadow_gen #(.CNT_W(32), .ADDR_W(4)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_half  (bus_half),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sync_in   (sync_in),
        .pwm_out   (pwm_out)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string phase = "R1";
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_per, m_cmp, m_psh, m_csh, m_cnt, m_rd;
    logic [4:0]  m_ctl;
    logic        m_rdv;
    logic        t_sync, t_wrap;
    logic [31:0] t_old, t_new;
    int          t_idx;

    function automatic logic [31:0] m_reg(input int i);
        case (i)
            0: return m_per;
            1: return m_cmp;
            2: return m_psh;
            3: return m_csh;
            4: return {27'd0, m_ctl};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic m_level();
        if (!m_ctl[1]) return 1'b0;
        return (m_cnt < m_cmp) ^ m_ctl[2];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_per = 0; m_cmp = 0; m_psh = 0; m_csh = 0; m_cnt = 0;
            m_ctl = 0; m_rd = 0; m_rdv = 0;
        end else begin
            t_idx  = int'(bus_addr[3:1]);
            t_old  = m_reg(t_idx);
            t_sync = m_ctl[0] && (m_ctl[4:3] != 2'b11) && sync_in;
            t_wrap = m_ctl[0] && !t_sync && (m_cnt == m_per);
            if (!bus_half) t_new = bus_wdata;
            else if (bus_addr[0]) t_new = {bus_wdata[15:0], t_old[15:0]};
            else t_new = {t_old[31:16], bus_wdata[15:0]};
            m_rdv = bus_sel && !bus_we;
            if (m_rdv) begin
                if (!bus_half) m_rd = t_old;
                else if (bus_addr[0]) m_rd = {16'd0, t_old[31:16]};
                else m_rd = {16'd0, t_old[15:0]};
            end
            if (m_ctl[0]) m_cnt = (t_sync || t_wrap) ? 32'd0 : m_cnt + 32'd1;
            else if (!m_ctl[1]) m_cnt = 32'd0;
            if (t_wrap) begin
                m_per = m_psh;
                m_cmp = m_csh;
            end
            if (bus_sel && bus_we) begin
                case (t_idx)
                    0: begin m_per = t_new; m_psh = t_new; end
                    1: begin m_cmp = t_new; m_csh = t_new; end
                    2: m_psh = t_new;
                    3: m_csh = t_new;
                    4: m_ctl = t_new[4:0];
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(pwm_out == m_level(), phase, 32'(pwm_out), 32'(m_level()));
            if (m_rdv) chk(bus_rdata == m_rd, "R2 read data", bus_rdata, m_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic h);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_half = h; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_half = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic h, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_half = h; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0; bus_half = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] v;
        int          hi;
        logic        prev;

        idle(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(pwm_out == 1'b0, "R1 output", 32'(pwm_out), 0);
        for (int a = 0; a < 10; a += 2) begin
            rd(4'(a), 1'b0, v);
            chk(v == 0, "R1 register", v, 0);
        end

        // R3: active writes mirror into shadow
        phase = "R3";
        wr(4'd0, 32'd9, 1'b0);
        wr(4'd2, 32'd3, 1'b0);
        rd(4'd4, 1'b0, v); chk(v == 32'd9, "R3 shadow period", v, 9);
        rd(4'd6, 1'b0, v); chk(v == 32'd3, "R3 shadow compare", v, 3);

        // R4 / R6: run with period 9, compare 3
        phase = "R4 R6 waveform";
        wr(4'd8, 32'h3, 1'b0);
        idle(25);
        count_high(10, hi);
        chk(hi == 3, "R6 high time per cycle", 32'(hi), 3);

        // R5: shadow update while running
        phase = "R5 shadow reload";
        wr(4'd4, 32'd5, 1'b0);
        wr(4'd6, 32'd2, 1'b0);
        idle(30);
        count_high(6, hi);
        chk(hi == 2, "R5 new high time", 32'(hi), 2);

        // R7: inverted polarity
        phase = "R7 invert";
        wr(4'd8, 32'h7, 1'b0);
        idle(8);
        count_high(6, hi);
        chk(hi == 4, "R7 inverted high time", 32'(hi), 4);
        wr(4'd8, 32'h3, 1'b0);

        // R6: compare 0 and compare above period
        phase = "R6 compare zero";
        wr(4'd6, 32'd0, 1'b0);
        idle(15);
        count_high(6, hi);
        chk(hi == 0, "R6 compare 0 constant low", 32'(hi), 0);
        phase = "R6 compare above period";
        wr(4'd6, 32'd20, 1'b0);
        idle(15);
        count_high(6, hi);
        chk(hi == 6, "R6 compare above period constant high", 32'(hi), 6);

        // R2: halfword access
        phase = "R2 halfword";
        wr(4'd7, 32'h0000_1234, 1'b1);
        rd(4'd6, 1'b0, v); chk(v == 32'h1234_0014, "R2 halfword write upper", v, 32'h1234_0014);
        rd(4'd7, 1'b1, v); chk(v == 32'h0000_1234, "R2 halfword read upper", v, 32'h1234);
        wr(4'd6, 32'h0000_0002, 1'b1);
        rd(4'd6, 1'b0, v); chk(v == 32'h1234_0002, "R2 halfword write lower", v, 32'h1234_0002);
        wr(4'd6, 32'd2, 1'b0);
        rd(4'd12, 1'b0, v); chk(v == 0, "R2 unmapped read", v, 0);
        idle(12);

        // R9: stop with wave enable held
        phase = "R9 hold";
        wr(4'd8, 32'h2, 1'b0);
        prev = pwm_out;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(pwm_out == prev, "R9 counter holds", 32'(pwm_out), 32'(prev));
        end

        // R8: wave enable cleared
        phase = "R8 R9 park";
        wr(4'd8, 32'h0, 1'b0);
        chk(pwm_out == 1'b0, "R8 output low after disable", 32'(pwm_out), 0);
        wr(4'd0, 32'd9, 1'b0);
        wr(4'd2, 32'd3, 1'b0);
        wr(4'd8, 32'h1, 1'b0);
        count_high(12, hi);
        chk(hi == 0, "R8 running without wave enable stays low", 32'(hi), 0);
        wr(4'd8, 32'h0, 1'b0);

        // R9 restart from zero, then R10 sync
        phase = "R10 sync";
        wr(4'd8, 32'h3, 1'b0);
        idle(6);
        pulse_sync();
        chk(pwm_out == 1'b1, "R10 sync restart high 0", 32'(pwm_out), 1);
        @(negedge clk); chk(pwm_out == 1'b1, "R10 sync restart high 1", 32'(pwm_out), 1);
        @(negedge clk); chk(pwm_out == 1'b1, "R10 sync restart high 2", 32'(pwm_out), 1);
        @(negedge clk); chk(pwm_out == 1'b0, "R10 sync restart low", 32'(pwm_out), 0);
        phase = "R10 sync disabled";
        wr(4'd8, 32'h1B, 1'b0);
        idle(3);
        pulse_sync();
        idle(6);
        pulse_sync();
        idle(12);
        rd(4'd8, 1'b0, v); chk(v == 32'h1B, "R2 control word", v, 32'h1B);
        rd(4'd9, 1'b1, v); chk(v == 0, "R2 control upper half", v, 0);

        // R11: active compare writes every clock across wraps
        phase = "R11 write vs wrap";
        wr(4'd8, 32'h0, 1'b0);
        wr(4'd0, 32'd3, 1'b0);
        wr(4'd4, 32'd3, 1'b0);
        wr(4'd6, 32'd0, 1'b0);
        wr(4'd8, 32'h3, 1'b0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_we = 1'b1; bus_half = 1'b0; bus_addr = 4'd2;
            bus_wdata = 32'((i % 4) + 1);
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        idle(10);

        // R4: minimum period toggles every clock
        phase = "R4 minimum period";
        wr(4'd8, 32'h0, 1'b0);
        wr(4'd0, 32'd1, 1'b0);
        wr(4'd2, 32'd1, 1'b0);
        wr(4'd8, 32'h3, 1'b0);
        @(negedge clk);
        prev = pwm_out;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(pwm_out != prev, "R4 period 1 toggles", 32'(pwm_out), 32'(!prev));
            prev = pwm_out;
        end

        idle(4);
        report();
    end

endmodule